// File: doc/BRIEF.md
# Power-Management Event and System Control Interrupt Unit

This block collects power-management events (real-time-clock alarm, power button press, global-lock release and PM timer overflow) into a 16-bit event status register. Software selects which events may interrupt through a 16-bit event enable register. The block drives a level interrupt line that stays high for as long as any selected event is both pending and enabled. Software acknowledges an event by writing a one to its status bit.

A free-running PM timer runs inside the block. Its overflow is armed only while the timer event is enabled and not already pending, so a pending timer event is not raised again until it is acknowledged. The two registers sit in a 64-byte window of the host I/O space. The window base comes from a 32-bit configuration value, with only bits [15:6] taken into account. Decoding is switched on by bit 0 of a configuration control byte, and it is off after reset.

Top module: `pm_evt_unit`

## Requirements
- R1: After reset, status and enable are 0, `sci_o` and `tmr_arm_o` are low, and the window does not decode (`bus_hit_o` low).
- R2: `bus_hit_o` is high exactly when `cfg_ctl_i[0]` is 1 and `bus_addr_i[15:6]` equals `cfg_base_i[15:6]`. Bits [31:16] and [5:0] of `cfg_base_i` are ignored.
- R3: While `cfg_ctl_i[0]` is 0, `bus_rdata_o` is 0 and writes leave both registers unchanged.
- R4: A read at window offset 0x00 returns status and a read at offset 0x02 returns enable. Every other offset reads 0. The status bits are: timer bit 0, global lock bit 5, power button bit 8, RTC bit 10. All other status bits always read 0.
- R5: A one-cycle pulse on an event input sets its status bit at the next clock edge, whatever the enable bit holds.
- R6: A write at offset 0x00 clears each status bit written as 1 and leaves bits written as 0 unchanged. An event that arrives in the same cycle as the clear wins, and its bit stays set.
- R7: A write at offset 0x02 stores all 16 bits of `bus_wdata_i` into enable.
- R8: `sci_o` is high exactly when status AND enable has bit 0, 5, 8 or 10 set. It follows register changes with no added delay.
- R9: `tmr_arm_o` is high exactly when enable bit 0 is 1 and status bit 0 is 0.
- R10: The PM timer is a `TMR_W`-bit counter that starts at 0 on reset and advances every cycle. Status bit 0 sets at each edge where the counter's top bit changes, but only if `tmr_arm_o` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ev_rtc_i | input | 1 | RTC alarm event pulse |
| ev_pwrbtn_i | input | 1 | Power button event pulse |
| ev_glock_i | input | 1 | Global lock event pulse |
| cfg_base_i | input | 32 | Window base configuration value |
| cfg_ctl_i | input | 8 | Decode control byte; bit 0 enables the window |
| bus_addr_i | input | 16 | Host I/O address |
| bus_wr_i | input | 1 | Host 16-bit write strobe |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Read data for the current address |
| bus_hit_o | output | 1 | Address falls inside the enabled window |
| sci_o | output | 1 | Level interrupt output |
| tmr_arm_o | output | 1 | Timer overflow armed |

## Verification
The hardest case to reach is a timer overflow that lands while the timer event is already pending, or while it is disabled. With a 24-bit counter, an overflow comes only once every several million cycles. The bench therefore builds the unit with a narrow timer, so the top bit changes every 128 cycles. It then keeps the timer status pending, or its enable cleared, across several overflows, and confirms that the bit is not set again. Random writes and events run over thousands of cycles, so clears meet overflows and event pulses in the same cycle. Each of these collisions is checked against a cycle-accurate model kept in the bench.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W   = 16;
  localparam int STS_TMR = 0;
  localparam int STS_GLK = 5;
  localparam int STS_PWR = 8;
  localparam int STS_RTC = 10;
  localparam logic [REG_W-1:0] SCI_MASK =
    REG_W'((1 << STS_TMR) | (1 << STS_GLK) | (1 << STS_PWR) | (1 << STS_RTC));
  localparam int OFF_STS = 0;
  localparam int OFF_EN  = 2;

  typedef struct packed {
    logic rtc;
    logic pwr;
    logic glk;
    logic tmr;
  } pm_evt_t;
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
  parameter int AW       = 16,
  parameter int CFG_W    = 32,
  parameter int WIN_BITS = 6
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [CFG_W-1:0] base_i,
  input  logic [7:0]       ctl_i,
  output logic             hit_o
);
  localparam logic [63:0] FULL_MASK = ((64'd1 << AW) - 64'd1) & ~((64'd1 << WIN_BITS) - 64'd1);
  localparam logic [CFG_W-1:0] WIN_MASK = FULL_MASK[CFG_W-1:0];

  logic [CFG_W-1:0] addr_ext;
  logic             dec_en;

  always_comb begin
    addr_ext = CFG_W'(addr_i);
    dec_en   = (ctl_i & 8'h01) != 8'h00;
    hit_o    = dec_en && ((addr_ext & WIN_MASK) == (base_i & WIN_MASK));
  end
endmodule

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
  parameter int TMR_W = 24
) (
  input  logic clk,
  input  logic rst_n,
  output logic ovf_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = 1'b1;
    cnt_d  = cnt_q + TMR_W'(1);
    ovf_o  = &cnt_q[TMR_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R10
  top_bit_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q[TMR_W-1] != $past(cnt_q[TMR_W-1])));
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  pm_evt_t          ev_i,
  input  logic             wr_sts_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] en_o,
  output logic             sci_o,
  output logic             arm_o
);
  logic [REG_W-1:0] sts_q, sts_d, en_q, set_v, clr_v;
  logic             sts_ce;

  always_comb begin
    arm_o = en_q[STS_TMR] & ~sts_q[STS_TMR];
    set_v = '0;
    set_v[STS_RTC] = ev_i.rtc;
    set_v[STS_PWR] = ev_i.pwr;
    set_v[STS_GLK] = ev_i.glk;
    set_v[STS_TMR] = ev_i.tmr & arm_o;
    clr_v  = wr_sts_i ? (wdata_i & SCI_MASK) : '0;
    sts_d  = (sts_q & ~clr_v) | set_v;
    sts_ce = wr_sts_i | (|set_v);
    sci_o  = |(sts_q & en_q & SCI_MASK);
    sts_o  = sts_q;
    en_o   = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_ce) sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_en_i) en_q <= wdata_i;
  end

  // R5
  rtc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.rtc |=> sts_q[STS_RTC]);
  // R5
  pwr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.pwr |=> sts_q[STS_PWR]);
  // R6
  pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts_i && wdata_i[STS_PWR] && !ev_i.pwr) |=> !sts_q[STS_PWR]);
  // R8
  sci_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & SCI_MASK) == '0) |-> !sci_o);
  // R9
  arm_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_o |-> en_q[STS_TMR]);
endmodule

// File: rtl/pm_evt_unit.sv
module pm_evt_unit
  import pm_evt_pkg::*;
#(
  parameter int TMR_W    = 24,
  parameter int AW       = 16,
  parameter int WIN_BITS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_rtc_i,
  input  logic             ev_pwrbtn_i,
  input  logic             ev_glock_i,
  input  logic [31:0]      cfg_base_i,
  input  logic [7:0]       cfg_ctl_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_wr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  output logic             bus_hit_o,
  output logic             sci_o,
  output logic             tmr_arm_o
);
  logic [WIN_BITS-1:0] off;
  logic                hit, wr_sts, wr_en, tmr_ovf;
  logic [REG_W-1:0]    sts, en;
  pm_evt_t             ev;

  pm_win_decode #(.AW(AW), .CFG_W(32), .WIN_BITS(WIN_BITS)) u_dec (
    .addr_i(bus_addr_i), .base_i(cfg_base_i), .ctl_i(cfg_ctl_i), .hit_o(hit));

  pm_tick_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ovf_o(tmr_ovf));

  always_comb begin
    off    = bus_addr_i[WIN_BITS-1:0];
    wr_sts = bus_wr_i && hit && (off == WIN_BITS'(OFF_STS));
    wr_en  = bus_wr_i && hit && (off == WIN_BITS'(OFF_EN));
    ev     = '{rtc: ev_rtc_i, pwr: ev_pwrbtn_i, glk: ev_glock_i, tmr: tmr_ovf};
  end

  pm_evt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .wr_sts_i(wr_sts), .wr_en_i(wr_en),
    .wdata_i(bus_wdata_i), .sts_o(sts), .en_o(en), .sci_o(sci_o), .arm_o(tmr_arm_o));

  always_comb begin
    bus_hit_o   = hit;
    bus_rdata_o = '0;
    if (hit && off == WIN_BITS'(OFF_STS)) bus_rdata_o = sts;
    else if (hit && off == WIN_BITS'(OFF_EN)) bus_rdata_o = en;
  end

  // R3
  no_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ctl_i[0] |-> (!bus_hit_o && bus_rdata_o == '0));
  // R6
  glk_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_glock_i && wr_sts) |=> sts[STS_GLK]);
endmodule

// File: tb/test_pm_evt_unit.sv
module test_pm_evt_unit;
  localparam int TW = 8;
  logic clk = 1'b0;
  logic rst_n;
  logic ev_rtc, ev_pwr, ev_glk, bus_wr, hit;
  logic [31:0] cfg_base;
  logic [7:0]  cfg_ctl;
  logic [15:0] bus_addr, bus_wdata, rdata;
  logic sci, arm;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [TW-1:0] m_cnt;
  logic [15:0]   m_sts, m_en;

  always #10 clk = ~clk;

  pm_evt_unit #(.TMR_W(TW)) i_pm_evt_unit (
    .clk(clk), .rst_n(rst_n), .ev_rtc_i(ev_rtc), .ev_pwrbtn_i(ev_pwr),
    .ev_glock_i(ev_glk), .cfg_base_i(cfg_base), .cfg_ctl_i(cfg_ctl),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(rdata), .bus_hit_o(hit), .sci_o(sci), .tmr_arm_o(arm));

  function automatic bit f_hit(logic [15:0] a, logic [31:0] b, logic [7:0] c);
    return c[0] && (a[15:6] == b[15:6]);
  endfunction
  function automatic logic [15:0] f_rd(logic [15:0] a, logic [31:0] b, logic [7:0] c,
                                       logic [15:0] s, logic [15:0] e);
    if (!f_hit(a, b, c)) return 16'h0;
    if (a[5:0] == 6'd0) return s;
    if (a[5:0] == 6'd2) return e;
    return 16'h0;
  endfunction
  function automatic bit f_sci(logic [15:0] s, logic [15:0] e);
    return |(s & e & 16'h0521);
  endfunction

  // reference model, one update per clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_sts <= '0; m_en <= '0;
    end else begin
      logic [15:0] set_v, clr_v;
      set_v = {5'b0, ev_rtc, 1'b0, ev_pwr, 2'b0, ev_glk, 4'b0,
               (&m_cnt[TW-2:0]) & m_en[0] & ~m_sts[0]};
      clr_v = (bus_wr && f_hit(bus_addr, cfg_base, cfg_ctl) && bus_addr[5:0] == 6'd0)
              ? (bus_wdata & 16'h0521) : 16'h0;
      m_sts <= (m_sts & ~clr_v) | set_v;
      if (bus_wr && f_hit(bus_addr, cfg_base, cfg_ctl) && bus_addr[5:0] == 6'd2)
        m_en <= bus_wdata;
      m_cnt <= m_cnt + 1'b1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle level checks against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R8 sci", sci, f_sci(m_sts, m_en));
    chk("R9 tmr_arm", arm, m_en[0] & ~m_sts[0]);
  end

  task automatic rd(input logic [15:0] a, output logic [15:0] d, output logic h);
    bus_addr = a; bus_wr = 0; #1; d = rdata; h = hit;
  endtask
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic pulse(input bit r, input bit p, input bit g);
    ev_rtc = r; ev_pwr = p; ev_glk = g;
    @(negedge clk); ev_rtc = 0; ev_pwr = 0; ev_glk = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  localparam logic [15:0] B = 16'h1240;

  initial begin
    logic [15:0] d; logic h; bit seen;
    int unsigned seed = 32'd41;
    void'($urandom(seed));
    rst_n = 0; ev_rtc = 0; ev_pwr = 0; ev_glk = 0; bus_wr = 0;
    bus_addr = B; bus_wdata = 0; cfg_base = 32'h0000_1240; cfg_ctl = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(B, d, h);
    chk("R1 hit off after reset", h, 0);
    chk("R1 sci low", sci, 0);
    chk("R1 arm low", arm, 0);
    cfg_ctl = 8'h01;
    rd(B, d, h);     chk("R1 status zero", d, 16'h0);
    rd(B + 2, d, h); chk("R1 enable zero", d, 16'h0);

    // events set status while disabled
    pulse(1, 0, 0);
    rd(B, d, h); chk("R5 rtc sets", d, 16'h0400); chk("R8 sci stays low", sci, 0);
    pulse(0, 1, 1);
    rd(B, d, h); chk("R5 pwr+glk set", d, 16'h0520);

    wr(B + 2, 16'hFFFE);
    rd(B + 2, d, h); chk("R7 enable stored", d, 16'hFFFE);
    chk("R8 sci high", sci, 1);

    wr(B, 16'h0000);
    rd(B, d, h); chk("R6 zero write no effect", d, 16'h0520);
    wr(B, 16'h0100);
    rd(B, d, h); chk("R6 clear pwr", d, 16'h0420);
    wr(B, 16'hFFFF);
    rd(B, d, h); chk("R6 clear all", d, 16'h0000); chk("R8 sci low after clear", sci, 0);

    ev_glk = 1; wr(B, 16'h0020); ev_glk = 0;
    rd(B, d, h); chk("R6 event wins over clear", d, 16'h0020);
    wr(B, 16'h0020);

    // decode disabled
    cfg_ctl = 8'hFE;
    wr(B + 2, 16'h0000);
    rd(B + 2, d, h); chk("R3 no hit", h, 0); chk("R3 rdata zero", d, 16'h0);
    cfg_ctl = 8'h01;
    rd(B + 2, d, h); chk("R3 enable kept", d, 16'hFFFE);

    // base low and high bits ignored
    cfg_base = 32'hABCD_127F;
    rd(16'h1242, d, h); chk("R2 hit with junk base bits", h, 1); chk("R4 enable read", d, 16'hFFFE);
    rd(16'h1282, d, h); chk("R2 next window miss", h, 0);
    rd(16'h1244, d, h); chk("R4 other offset zero", d, 16'h0);
    rd(16'h1241, d, h); chk("R4 odd offset zero", d, 16'h0);
    cfg_base = 32'h0000_1240;

    // timer overflow
    wr(B + 2, 16'h0001);
    chk("R9 armed", arm, 1);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk); rd(B, d, h); seen = d[0];
    end
    chk("R10 timer status set", seen, 1);
    chk("R9 disarmed while pending", arm, 0);
    chk("R8 sci from timer", sci, 1);
    repeat (300) @(negedge clk);
    rd(B, d, h); chk("R10 pending across overflows", d, 16'h0001);
    wr(B + 2, 16'h0000); wr(B, 16'h0001);
    repeat (300) @(negedge clk);
    rd(B, d, h); chk("R10 no set when disabled", d, 16'h0000);

    // random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int unsigned r = $urandom % 100;
      ev_rtc = ($urandom % 8) == 0;
      ev_pwr = ($urandom % 8) == 0;
      ev_glk = ($urandom % 8) == 0;
      if (cyc % 200 == 0) begin
        cfg_base = 32'h1240 | ($urandom & 32'hFFFF_003F);
        cfg_ctl  = 8'($urandom) | (($urandom % 10) != 0 ? 8'h01 : 8'h00);
      end
      if (r < 50) bus_addr = B;
      else if (r < 75) bus_addr = B + 2;
      else if (r < 90) bus_addr = B | 16'($urandom % 64);
      else bus_addr = 16'($urandom);
      bus_wdata = ($urandom % 4 == 0) ? 16'h0001 : 16'($urandom);
      bus_wr = ($urandom % 3) == 0;
      #1;
      chk("R2 hit", hit, f_hit(bus_addr, cfg_base, cfg_ctl));
      chk("R4 rdata", rdata, f_rd(bus_addr, cfg_base, cfg_ctl, m_sts, m_en));
      @(negedge clk);
    end
    ev_rtc = 0; ev_pwr = 0; ev_glk = 0; bus_wr = 0;
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule